// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves blocks of data between peripherals and memory for a host processor, one channel at a time. Each of the four channels has a request input, an acknowledge output, a 16-bit address register and a 16-bit count register. The host programs these registers over a byte-wide register port. When an enabled channel raises its request, the controller asks for the system bus and waits for the grant. It then acknowledges the winning peripheral, drives the channel address and issues the memory and I/O strobes that the channel's transfer type needs. It keeps the bus for a burst of transfers while the request stays high.

A mode register enables channels and selects four options: rotating priority, early write strobes, disabling a channel at terminal count, and reloading channel 2 from channel 3. A status register records which channels have reached terminal count and whether a reload has happened.

Top module: `dma_ctrl4`

## Requirements
- R1: Register port. A host access takes effect when `cs_i` is high. With `addr_i[3]=0`, `addr_i[2:1]` picks the channel and `addr_i[0]` picks the register (0 = address, 1 = count). Each channel register is accessed a byte at a time through one shared byte pointer, low byte first. The pointer toggles on every channel-register read or write and returns to the low byte when the mode register is written. Reads return the current register contents.
- R2: A write with `addr_i[3]=1` loads the mode register. Bits 3:0 enable channels 0 to 3, bit 4 selects rotating priority, bit 5 selects early write, bit 6 selects stop at terminal count and bit 7 selects autoload.
- R3: Bus handshake. An enabled request raises `hold_o` on the next cycle. Once `hlda_i` is seen, each transfer takes two cycles: phase A, then phase B. During both phases exactly one `dack_o` bit is high, the one for the serviced channel. No `dack_o` bit is high while `hold_o` is low.
- R4: During a transfer `addr_o` carries the channel address. After each phase B the address increments and bits 13:0 of the count decrement. A count value of N-1 gives N transfers. Bits 15:14 of the count are kept. After terminal count, the count bits wrap to 0x3FFF.
- R5: Count bits 15:14 select the transfer type: 00 verify, 01 write, 10 read, 11 illegal. For read, `mem_rd_o` is high in both phases and `io_wr_o` is high in phase B. For write, `io_rd_o` is high in both phases and `mem_wr_o` is high in phase B. With early write, the write strobe is also high in phase A. Verify and illegal drive no strobes.
- R6: `tc_o` is high in phase B of the transfer in which the count bits are zero. The controller then drops `hold_o` and sets that channel's status bit.
- R7: The burst continues while the serviced request stays high. If the request is low at the end of phase B, the bus is released. The address and count keep their progress so that a later request resumes the transfer.
- R8: Under fixed priority, the lowest-numbered pending channel wins.
- R9: Under rotating priority, the channel that was just serviced becomes the lowest priority, and the next-higher channel number becomes the highest.
- R10: With stop at terminal count, a channel's enable bit clears at its terminal count, and its later requests raise no `hold_o`.
- R11: With autoload, terminal count on channel 2 copies channel 3's address and count into channel 2 and sets status bit 4.
- R12: A read with `addr_i[3]=1` returns {3'b000, update, tc3..tc0} and clears the status. A bit set in the same cycle as the clearing read survives.
- R13: After reset, `hold_o`, `dack_o`, all strobes, `tc_o` and the status register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register port select |
| rd_i | input | 1 | Register read |
| wr_i | input | 1 | Register write |
| addr_i | input | 4 | Register select |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| drq_i | input | 4 | Channel requests |
| dack_o | output | 4 | Channel acknowledges |
| hold_o | output | 1 | Bus request to host |
| hlda_i | input | 1 | Bus grant from host |
| addr_o | output | 16 | Transfer address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| tc_o | output | 1 | Terminal count indicator |

## Verification
Two events can land on the same clock edge: a host read of the status register, which clears it, and the phase B of a final transfer, which sets a terminal-count bit (and, with autoload, the update bit). The bench places a status read exactly on the phase B cycle of a single-transfer burst. It expects the read data to show the bit still clear, and the next status read to return the bit set. Channel 2 reloading from channel 3 at terminal count is judged the same way, through the status bits and through readback of the reloaded registers.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int NCH     = 4;
  localparam int CH_W    = $clog2(NCH);
  localparam int ADDR_W  = 16;
  localparam int CNT_W   = 14;
  localparam int REG_W   = CNT_W + 2;
  localparam int MODE_W  = NCH + 4;
  localparam int STAT_W  = NCH + 1;

  localparam int MODE_ROT    = NCH;
  localparam int MODE_EXTW   = NCH + 1;
  localparam int MODE_TCSTOP = NCH + 2;
  localparam int MODE_AUTO   = NCH + 3;
  localparam int STAT_UPD    = NCH;
  localparam int AL_DST      = 2;
  localparam int AL_SRC      = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_XA, ST_XB} dma_state_e;
  typedef enum logic [1:0] {
    XF_VERIFY  = 2'b00,
    XF_WRITE   = 2'b01,
    XF_READ    = 2'b10,
    XF_ILLEGAL = 2'b11
  } xfer_kind_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_cnt_i,
  input  logic              wr_hi_i,
  input  logic [7:0]        wdata_i,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [REG_W-1:0]  load_cnt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [REG_W-1:0]  cnt_o,
  output logic              tc_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= load_addr_i;
      cnt_q  <= load_cnt_i;
    end else if (step_i) begin
      addr_q             <= addr_q + 1'b1;
      cnt_q[CNT_W-1:0]   <= cnt_q[CNT_W-1:0] - 1'b1;
    end else if (wr_i) begin
      if (wr_cnt_i) begin
        if (wr_hi_i) cnt_q[15:8] <= wdata_i;
        else         cnt_q[7:0]  <= wdata_i;
      end else begin
        if (wr_hi_i) addr_q[15:8] <= wdata_i;
        else         addr_q[7:0]  <= wdata_i;
      end
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign tc_o   = (cnt_q[CNT_W-1:0] == '0);

  // R4
  step_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_o == $past(addr_o) + 16'd1) &&
                            (cnt_o[CNT_W-1:0] == $past(cnt_o[CNT_W-1:0]) - 14'd1) &&
                            (cnt_o[REG_W-1:CNT_W] == $past(cnt_o[REG_W-1:CNT_W])));
  // R11
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(load_addr_i)) && (cnt_o == $past(load_cnt_i)));
endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_pkg::*;
(
  input  logic [NCH-1:0]  req_i,
  input  logic            rot_i,
  input  logic [CH_W-1:0] base_i,
  output logic            any_o,
  output logic [CH_W-1:0] idx_o
);
  logic [CH_W-1:0] cand;

  // scan from lowest to highest priority so the last hit is the winner
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    cand  = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      cand = rot_i ? CH_W'(base_i + CH_W'(k)) : CH_W'(k);
      if (req_i[cand]) begin
        any_o = 1'b1;
        idx_o = cand;
      end
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       any_i,
  input  logic       hlda_i,
  input  logic       drq_cur_i,
  input  logic       en_cur_i,
  input  logic       tc_i,
  output dma_state_e state_o,
  output logic       grab_o,
  output logic       step_o,
  output logic       release_o
);
  dma_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: if (any_i) state_n = ST_WAIT;
      ST_WAIT: begin
        if (!any_i)      state_n = ST_IDLE;
        else if (hlda_i) state_n = ST_XA;
      end
      ST_XA:   state_n = hlda_i ? ST_XB : ST_IDLE;
      ST_XB: begin
        if (!hlda_i || tc_i || !drq_cur_i || !en_cur_i) state_n = ST_IDLE;
        else                                            state_n = ST_XA;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_n;
  end

  assign state_o   = state_q;
  assign grab_o    = (state_q == ST_WAIT) && any_i && hlda_i;
  assign step_o    = (state_q == ST_XB);
  assign release_o = step_o && (state_n == ST_IDLE);

  // R3
  phase_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_XB) |-> $past(state_o) == ST_XA);
endmodule

// File: rtl/dma_ctrl4.sv
module dma_ctrl4
  import dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [3:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [NCH-1:0]    drq_i,
  output logic [NCH-1:0]    dack_o,
  output logic              hold_o,
  input  logic              hlda_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              io_rd_o,
  output logic              io_wr_o,
  output logic              tc_o
);
  dma_state_e        state;
  logic [CH_W-1:0]   cur_q, base_q, arb_idx;
  logic              arb_any, grab, step, release_b;
  logic [MODE_W-1:0] mode_q;
  logic [STAT_W-1:0] stat_q, stat_set;
  logic              hi_q;
  logic [NCH-1:0]    pending, ch_tc;
  logic [ADDR_W-1:0] ch_addr [NCH];
  logic [REG_W-1:0]  ch_cnt  [NCH];
  logic [REG_W-1:0]  rd_sel;
  logic              mode_wr, stat_rd, reg_acc, cur_tc, al_fire, active, wr_phase;
  xfer_kind_e        kind;

  assign pending = drq_i & mode_q[NCH-1:0];
  assign mode_wr = cs_i & wr_i & addr_i[3];
  assign stat_rd = cs_i & rd_i & addr_i[3];
  assign reg_acc = cs_i & (rd_i | wr_i) & ~addr_i[3];
  assign cur_tc  = ch_tc[cur_q];
  assign al_fire = step & cur_tc & mode_q[MODE_AUTO] & (cur_q == CH_W'(AL_DST));

  dma_arb u_arb (
    .req_i  (pending),
    .rot_i  (mode_q[MODE_ROT]),
    .base_i (base_q),
    .any_o  (arb_any),
    .idx_o  (arb_idx)
  );

  dma_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .any_i     (arb_any),
    .hlda_i    (hlda_i),
    .drq_cur_i (drq_i[cur_q]),
    .en_cur_i  (mode_q[cur_q]),
    .tc_i      (cur_tc),
    .state_o   (state),
    .grab_o    (grab),
    .step_o    (step),
    .release_o (release_b)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    dma_chan u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (cs_i & wr_i & ~addr_i[3] & (addr_i[2:1] == CH_W'(k))),
      .wr_cnt_i    (addr_i[0]),
      .wr_hi_i     (hi_q),
      .wdata_i     (wdata_i),
      .step_i      (step & (cur_q == CH_W'(k))),
      .load_i      ((k == AL_DST) ? al_fire : 1'b0),
      .load_addr_i (ch_addr[AL_SRC]),
      .load_cnt_i  (ch_cnt[AL_SRC]),
      .addr_o      (ch_addr[k]),
      .cnt_o       (ch_cnt[k]),
      .tc_o        (ch_tc[k])
    );
  end

  always_comb begin
    stat_set = '0;
    if (step && cur_tc) stat_set[cur_q]    = 1'b1;
    if (al_fire)        stat_set[STAT_UPD] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      stat_q <= '0;
      hi_q   <= 1'b0;
      cur_q  <= '0;
      base_q <= '0;
    end else begin
      if (mode_wr)      hi_q <= 1'b0;
      else if (reg_acc) hi_q <= ~hi_q;
      if (mode_wr) mode_q <= wdata_i;
      else if (step && cur_tc && mode_q[MODE_TCSTOP]) mode_q[cur_q] <= 1'b0;
      // a bit set on the clearing read survives
      stat_q <= (stat_rd ? '0 : stat_q) | stat_set;
      if (grab)      cur_q  <= arb_idx;
      if (release_b) base_q <= cur_q + 1'b1;
    end
  end

  assign active   = (state == ST_XA) || (state == ST_XB);
  assign wr_phase = (state == ST_XB) || ((state == ST_XA) && mode_q[MODE_EXTW]);
  assign kind     = xfer_kind_e'(ch_cnt[cur_q][REG_W-1:CNT_W]);

  assign hold_o   = (state != ST_IDLE);
  assign dack_o   = active ? (NCH'(1) << cur_q) : '0;
  assign addr_o   = active ? ch_addr[cur_q] : '0;
  assign mem_rd_o = active   && (kind == XF_READ);
  assign io_wr_o  = wr_phase && (kind == XF_READ);
  assign io_rd_o  = active   && (kind == XF_WRITE);
  assign mem_wr_o = wr_phase && (kind == XF_WRITE);
  assign tc_o     = (state == ST_XB) && cur_tc;

  always_comb begin
    rd_sel = addr_i[0] ? ch_cnt[addr_i[2:1]] : ch_addr[addr_i[2:1]];
    if (addr_i[3]) rdata_o = 8'(stat_q);
    else           rdata_o = hi_q ? rd_sel[15:8] : rd_sel[7:0];
  end

  // R3
  dack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_o));
  // R3
  dack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o != '0) |-> hold_o);
  // R6
  tc_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !hold_o);
  // R6
  tc_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> stat_q[$past(cur_q)]);
  // R8
  grant_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grab |-> pending[arb_idx]);
  // R10
  tc_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && mode_q[MODE_TCSTOP] && !mode_wr) |=> !mode_q[$past(cur_q)]);
  // R12
  stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !step) |=> (stat_q == '0));
endmodule

// File: tb/dma_ctrl4_tb_top.sv
module dma_ctrl4_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_READ  = 2'b10;
  localparam logic [1:0] K_WRITE = 2'b01;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs = 0, rd = 0, wr = 0, hlda = 0;
  logic [3:0]  addr = '0, drq = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [3:0]  dack;
  logic        hold, mem_rd, mem_wr, io_rd, io_wr, tc;
  logic [15:0] xaddr;
  int n_chk = 0, n_bad = 0;

  dma_ctrl4 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .drq_i(drq), .dack_o(dack), .hold_o(hold),
    .hlda_i(hlda), .addr_o(xaddr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .io_rd_o(io_rd), .io_wr_o(io_wr), .tc_o(tc)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // {mem_rd, mem_wr, io_rd, io_wr}
  function automatic logic [3:0] exp_strb(logic [1:0] kind, bit ph_b, bit ext);
    bit w = ph_b || ext;
    case (kind)
      K_READ:  return {1'b1, 1'b0, 1'b0, w};
      K_WRITE: return {1'b0, w, 1'b1, 1'b0};
      default: return 4'b0000;
    endcase
  endfunction

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr_reg(a, v[7:0]); wr_reg(a, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(a, lo); rd_reg(a, hi);
    v = {hi, lo};
  endtask

  task automatic program_ch(input logic [1:0] c, input logic [15:0] a, input logic [15:0] n);
    wr16({1'b0, c, 1'b0}, a);
    wr16({1'b0, c, 1'b1}, n);
  endtask

  task automatic chk_stat(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd_reg(4'h8, v); chk(req, v, exp);
  endtask

  task automatic run_burst(input logic [1:0] c, input logic [15:0] start, input int n,
                           input logic [1:0] kind, input bit ext);
    for (int w = 0; w < 50 && dack == 4'b0; w++) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk("R3 dack phase A", dack, 4'b1 << c);
      chk("R4 addr phase A", xaddr, 16'(start + i));
      chk("R5 strobes phase A", {mem_rd, mem_wr, io_rd, io_wr}, exp_strb(kind, 0, ext));
      @(negedge clk);
      chk("R4 addr phase B", xaddr, 16'(start + i));
      chk("R5 strobes phase B", {mem_rd, mem_wr, io_rd, io_wr}, exp_strb(kind, 1, ext));
      chk("R6 tc phase B", tc, (i == n - 1));
      if (i == n - 1) drq[c] = 1'b0;
      @(negedge clk);
    end
    chk("R6 release after tc", {hold, dack}, 5'b0);
  endtask

  initial forever begin
    @(negedge clk);
    hlda = hold;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v16;
    logic [7:0]  v8;
    int unsigned seed_init;
    seed_init = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 outputs", {hold, dack, mem_rd, mem_wr, io_rd, io_wr, tc}, 10'b0);
    chk_stat("R13 status", 8'h00);

    // R1 readback, byte pointer
    program_ch(2'd1, 16'hBEEF, 16'h8005);
    rd16(4'h2, v16); chk("R1 addr readback", v16, 16'hBEEF);
    rd16(4'h3, v16); chk("R1 count readback", v16, 16'h8005);

    // R2 R4 R5 R6 R12 random bursts, fixed priority
    for (int t = 0; t < 16; t++) begin
      logic [1:0]  c, kind;
      logic [15:0] st;
      int n;
      bit ext;
      c = 2'($urandom % 4); kind = 2'($urandom % 4); ext = 1'($urandom % 2);
      n = 1 + int'($urandom % 5); st = 16'($urandom);
      program_ch(c, st, {kind, 14'(n - 1)});
      wr_reg(4'h8, 8'((1 << c) | (int'(ext) << 5)));
      drq[c] = 1'b1;
      run_burst(c, st, n, kind, ext);
      chk_stat("R12 status after burst", 8'(1 << c));
      chk_stat("R12 status cleared", 8'h00);
      rd16({1'b0, c, 1'b0}, v16); chk("R4 addr after burst", v16, 16'(st + n));
      rd16({1'b0, c, 1'b1}, v16); chk("R4 count wraps", v16, {kind, 14'h3FFF});
    end

    // R8 fixed priority: 1 before 3
    program_ch(2'd1, 16'h1000, {K_READ, 14'd0});
    program_ch(2'd3, 16'h3000, {K_WRITE, 14'd0});
    wr_reg(4'h8, 8'h0F);
    drq[1] = 1'b1; drq[3] = 1'b1;
    run_burst(2'd1, 16'h1000, 1, K_READ, 0);
    run_burst(2'd3, 16'h3000, 1, K_WRITE, 0);
    chk_stat("R8 status", 8'h0A);

    // R9 rotating: after serving 1, channel 3 outranks 0
    program_ch(2'd1, 16'h1100, {K_READ, 14'd0});
    wr_reg(4'h8, 8'h1F);
    drq[1] = 1'b1;
    run_burst(2'd1, 16'h1100, 1, K_READ, 0);
    program_ch(2'd0, 16'h0100, {K_READ, 14'd0});
    program_ch(2'd3, 16'h3300, {K_READ, 14'd0});
    drq[0] = 1'b1; drq[3] = 1'b1;
    run_burst(2'd3, 16'h3300, 1, K_READ, 0);
    run_burst(2'd0, 16'h0100, 1, K_READ, 0);
    chk_stat("R9 status", 8'h0B);

    // R7 burst broken by request drop, then resumed
    program_ch(2'd0, 16'h4000, {K_READ, 14'd4});
    wr_reg(4'h8, 8'h01);
    drq[0] = 1'b1;
    for (int w = 0; w < 50 && dack == 4'b0; w++) @(negedge clk);
    @(negedge clk); @(negedge clk); @(negedge clk);
    drq[0] = 1'b0;
    @(negedge clk);
    chk("R7 released on drop", {hold, dack}, 5'b0);
    rd16(4'h0, v16); chk("R7 addr progress", v16, 16'h4002);
    rd16(4'h1, v16); chk("R7 count progress", v16, {K_READ, 14'd2});
    drq[0] = 1'b1;
    run_burst(2'd0, 16'h4002, 3, K_READ, 0);
    chk_stat("R7 status", 8'h01);

    // R10 stop at terminal count, with early write (R5)
    program_ch(2'd0, 16'h5000, {K_WRITE, 14'd1});
    wr_reg(4'h8, 8'h61);
    drq[0] = 1'b1;
    run_burst(2'd0, 16'h5000, 2, K_WRITE, 1);
    drq[0] = 1'b1;
    begin
      bit seen = 0;
      repeat (6) begin @(negedge clk); if (hold) seen = 1; end
      chk("R10 request ignored after tc", seen, 1'b0);
    end
    drq[0] = 1'b0;
    chk_stat("R10 status", 8'h01);

    // R12 clearing read on the same edge as terminal count
    program_ch(2'd2, 16'h6000, {K_READ, 14'd0});
    wr_reg(4'h8, 8'h04);
    drq[2] = 1'b1;
    for (int w = 0; w < 50 && dack == 4'b0; w++) @(negedge clk);
    @(negedge clk);
    cs = 1; rd = 1; addr = 4'h8; drq[2] = 1'b0;
    #1 chk("R12 read during tc", rdata, 8'h00);
    @(negedge clk); cs = 0; rd = 0;
    chk_stat("R12 set wins over clear", 8'h04);
    chk_stat("R12 cleared after", 8'h00);

    // R11 autoload channel 2 from channel 3
    program_ch(2'd3, 16'h7700, {K_WRITE, 14'd2});
    program_ch(2'd2, 16'h6600, {K_READ, 14'd0});
    wr_reg(4'h8, 8'h84);
    drq[2] = 1'b1;
    run_burst(2'd2, 16'h6600, 1, K_READ, 0);
    chk_stat("R11 status with update", 8'h14);
    rd16(4'h4, v16); chk("R11 reloaded addr", v16, 16'h7700);
    rd16(4'h5, v16); chk("R11 reloaded count", v16, {K_WRITE, 14'd2});
    drq[2] = 1'b1;
    run_burst(2'd2, 16'h7700, 3, K_WRITE, 0);
    chk_stat("R11 second status", 8'h14);

    v8 = 8'h00;
    chk("R13 idle at end", {hold, dack, v8}, 13'b0);
    summary();
  end
endmodule